// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a target on a two-wire serial management bus (SMBus/I2C style). It exposes eight 8-bit control bytes to a host and drives those bytes, as a flat vector, to the clock-generation logic around it. Both transfer directions are indexed block transfers. A write carries a starting index and a byte count. A read returns a byte count ahead of the data.

The bus lines arrive asynchronously and are oversampled by the system clock. The block runs a byte-level state machine on the sampled SCL edges. It recognises START, repeated START and STOP conditions. It acknowledges the bytes it accepts, steps the register index after every data byte, and pulls SDA low through an open-drain enable.

Control bytes 0 to 2 are output-enable masks. Bit 0 of byte 1 switches spread-spectrum modulation on or off. Bytes 3 to 5 hold the stop-permission and drive-mode bits. The three low bits of byte 6 read back the frequency-select straps. Byte 7 is a fixed identity byte made of a revision nibble and a vendor nibble. Index 8 is a write-only slot that sets the count byte returned by reads.

Top module: `smbus_reg_target`

## Requirements
- R1: The target acknowledges an address byte of 0xD2 (write) or 0xD3 (read). Any other address byte is not acknowledged, because SDA is left released during the ninth clock. After that, no further byte is acknowledged or stored until the next START.
- R2: A write runs as follows: START, 0xD2, index N, count X, then data bytes. The first X data bytes are stored to indexes N, N+1, ... N+X-1. Every byte of the transfer is acknowledged.
- R3: Data bytes sent after the count X is used up are acknowledged and discarded.
- R4: After reset the control bytes read as follows: bytes 0, 1 and 2 = 0xFF, so byte 1 bit 0 (spread on) = 1; byte 3 = 0x00; byte 4 = 0x07; byte 5 = 0x00; byte 6 bits 7:3 = 00001; the read count = 8. Byte i appears on `ctrlOut[8*i+7:8*i]`.
- R5: A read runs as follows: START, 0xD2, index N, repeated START, 0xD3. The target then sends the count byte, followed by the bytes at N, N+1, ... each MSB first. It keeps sending while the host acknowledges. It stops driving once the host gives a NACK.
- R6: Byte 6 bits 2:0 always equal `strapIn`. Byte 7 always equals {`revId`, `vendorId`}. Writes to these bits are discarded.
- R7: Writing index 8 sets the count byte that later reads return. Reads of index 8 and above return 0x00. Writes to indexes above 8 are discarded.
- R8: `sdaPullDown` changes only while SCL is low. The control bytes change only while SCL is low.
- R9: A STOP at any point ends the transfer and releases SDA. Bytes already stored stay stored, and the next START is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullDown | output | 1 | When high, the pad pulls SDA low |
| strapIn | input | 3 | Latched frequency-select straps, read back in byte 6 bits 2:0 |
| revId | input | 4 | Revision nibble, read back in byte 7 bits 7:4 |
| vendorId | input | 4 | Vendor nibble, read back in byte 7 bits 3:0 |
| ctrlOut | output | 64 | Control bytes 0..7, byte i at bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: eight control bytes, addresses 0xD2/0xD3, a read count of 8 and two synchronizer stages. With these values a sweep of write starting indexes from 0 to 8, each writing to the end of the map, covers every control byte, the read-only positions and the count slot. A read sweep from index 0 to 10 then reaches the unmapped indexes. Directed transfers cover a rejected address, surplus data bytes, a STOP in the middle of a write and a strap change. Expected bytes come from a write-mask model in the bench.

// File: rtl/smbus_reg_pkg.sv
package smbus_reg_pkg;

  localparam int BYTE_W    = 8;
  localparam int STRAP_IDX = 6;
  localparam int STRAP_W   = 3;
  localparam int ID_IDX    = 7;
  localparam int NIB_W     = 4;

  typedef struct packed {
    logic              wrEn;
    logic [BYTE_W-1:0] idx;
    logic [BYTE_W-1:0] data;
  } regCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } busState_e;

  typedef enum logic [2:0] {
    ROLE_ADDR, ROLE_INDEX, ROLE_COUNT, ROLE_DATA, ROLE_RDADDR
  } byteRole_e;

  function automatic logic [BYTE_W-1:0] resetValue(input int i);
    case (i)
      0, 1, 2:   return 8'hFF;
      4:         return 8'h07;
      STRAP_IDX: return 8'h08;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] writeMask(input int i);
    case (i)
      STRAP_IDX: return 8'hF8;
      ID_IDX:    return 8'h00;
      default:   return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smbus_reg_ctrl.sv
module smbus_reg_ctrl
  import smbus_reg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] cntData,
  output regCmd_t           cmd,
  output logic              sdaPullDown
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startEv, stopEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_e         state;
  byteRole_e         role;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftReg, txByte, idx, remain;
  logic              byteDone, wrEn;

  assign byteDone = (state == ST_RX) && (bitCnt == LAST_BIT) && sclFall;
  assign wrEn     = byteDone && (role == ROLE_DATA) && (remain != '0);

  always_comb begin
    cmd.wrEn = wrEn;
    cmd.idx  = idx;
    cmd.data = shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      role        <= ROLE_ADDR;
      bitCnt      <= '0;
      shiftReg    <= '0;
      txByte      <= '0;
      idx         <= '0;
      remain      <= '0;
      sdaPullDown <= 1'b0;
    end else if (startEv) begin
      state       <= ST_RX;
      role        <= ROLE_ADDR;
      bitCnt      <= '0;
      sdaPullDown <= 1'b0;
    end else if (stopEv) begin
      state       <= ST_IDLE;
      sdaPullDown <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
            bitCnt   <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            unique case (role)
              ROLE_ADDR: begin
                if (shiftReg == WR_ADDR) begin
                  role        <= ROLE_INDEX;
                  state       <= ST_RX_ACK;
                  sdaPullDown <= 1'b1;
                end else if (shiftReg == RD_ADDR) begin
                  role        <= ROLE_RDADDR;
                  state       <= ST_RX_ACK;
                  sdaPullDown <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ROLE_INDEX: begin
                idx         <= shiftReg;
                role        <= ROLE_COUNT;
                state       <= ST_RX_ACK;
                sdaPullDown <= 1'b1;
              end
              ROLE_COUNT: begin
                remain      <= shiftReg;
                role        <= ROLE_DATA;
                state       <= ST_RX_ACK;
                sdaPullDown <= 1'b1;
              end
              default: begin
                if (remain != '0) begin
                  idx    <= idx + 8'd1;
                  remain <= remain - 8'd1;
                end
                state       <= ST_RX_ACK;
                sdaPullDown <= 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            if (role == ROLE_RDADDR) begin
              state       <= ST_TX;
              txByte      <= cntData;
              sdaPullDown <= ~cntData[BYTE_W-1];
              bitCnt      <= '0;
            end else begin
              state       <= ST_RX;
              sdaPullDown <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              state       <= ST_TX_ACK;
              sdaPullDown <= 1'b0;
            end else begin
              txByte      <= {txByte[BYTE_W-2:0], 1'b0};
              sdaPullDown <= ~txByte[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            if (sdaNow) state <= ST_IDLE;
          end else if (sclFall) begin
            state       <= ST_TX;
            txByte      <= rdData;
            sdaPullDown <= ~rdData[BYTE_W-1];
            idx         <= idx + 8'd1;
            bitCnt      <= '0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smbus_reg_file.sv
module smbus_reg_file
  import smbus_reg_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [7:0] DEF_COUNT = 8'd8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regCmd_t                    cmd,
  input  logic [STRAP_W-1:0]         strapIn,
  input  logic [NIB_W-1:0]           revId,
  input  logic [NIB_W-1:0]           vendorId,
  output logic [BYTE_W-1:0]          rdData,
  output logic [BYTE_W-1:0]          cntData,
  output logic [NUM_REGS*BYTE_W-1:0] ctrlOut
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    if (g == ID_IDX) begin : g_id
      assign view[g] = {revId, vendorId};
    end else begin : g_store
      localparam logic [BYTE_W-1:0] MASK = writeMask(g);
      logic [BYTE_W-1:0] store;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          store <= resetValue(g);
        else if (cmd.wrEn && cmd.idx == 8'(g))
          store <= (store & ~MASK) | (cmd.data & MASK);
      end
      if (g == STRAP_IDX) begin : g_strap
        assign view[g] = {store[BYTE_W-1:STRAP_W], strapIn};
      end else begin : g_plain
        assign view[g] = store;
      end
    end
    assign ctrlOut[g*BYTE_W +: BYTE_W] = view[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntData <= DEF_COUNT;
    else if (cmd.wrEn && cmd.idx == 8'(NUM_REGS))
      cntData <= cmd.data;
  end

  always_comb begin
    if (cmd.idx < 8'(NUM_REGS))
      rdData = view[cmd.idx[IDX_W-1:0]];
    else
      rdData = '0;
  end

endmodule

// File: rtl/smbus_reg_target.sv
module smbus_reg_target
  import smbus_reg_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter logic [7:0] DEF_COUNT   = 8'd8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaPullDown,
  input  logic [STRAP_W-1:0]         strapIn,
  input  logic [NIB_W-1:0]           revId,
  input  logic [NIB_W-1:0]           vendorId,
  output logic [NUM_REGS*BYTE_W-1:0] ctrlOut
);

  regCmd_t           cmdBus;
  logic [BYTE_W-1:0] rdData, cntData;

  smbus_reg_ctrl #(
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .cntData(cntData), .cmd(cmdBus),
    .sdaPullDown(sdaPullDown)
  );

  smbus_reg_file #(
    .NUM_REGS(NUM_REGS), .DEF_COUNT(DEF_COUNT)
  ) file_i (
    .clk(clk), .rstN(rstN), .cmd(cmdBus), .strapIn(strapIn),
    .revId(revId), .vendorId(vendorId), .rdData(rdData),
    .cntData(cntData), .ctrlOut(ctrlOut)
  );

endmodule

// File: rtl/smbus_reg_target_chk.sv
module smbus_reg_target_chk
  import smbus_reg_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          sclIn,
  input logic                          sdaPullDown,
  input logic                          wrStrobe,
  input logic [STRAP_IDX*BYTE_W-1:0]   ctrlLow
);

  // R8
  pulldown_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> !sclIn);

  // R8
  cfg_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlLow) |-> !sclIn);

  // R2
  write_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> sdaPullDown);

  // R2
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R8
  write_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !sclIn);

endmodule

bind smbus_reg_target smbus_reg_target_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .wrStrobe(cmdBus.wrEn),
  .ctrlLow(ctrlOut[smbus_reg_pkg::STRAP_IDX*8-1:0])
);

// File: tb/smbus_reg_target_tb.sv
module smbus_reg_target_tb_top;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic hostLow = 1'b0;
  logic sdaIn, sdaPullDown;
  logic [2:0] strapIn = 3'b010;
  logic [3:0] revId = 4'h3;
  logic [3:0] vendorId = 4'h1;
  logic [63:0] ctrlOut;

  int checks = 0;
  int errors = 0;
  int pdViolations = 0;
  logic prevPd = 1'b0;

  logic [7:0] model [9];
  logic [7:0] txBuf [16];

  always #10 clk = ~clk;

  assign sdaIn = !(hostLow || sdaPullDown);

  smbus_reg_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaIn),
    .sdaPullDown(sdaPullDown), .strapIn(strapIn), .revId(revId),
    .vendorId(vendorId), .ctrlOut(ctrlOut)
  );

  // R8 monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rstN && (sdaPullDown != prevPd) && sclDrv) pdViolations++;
    prevPd <= sdaPullDown;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input int i);
    if (i < 6) return model[i];
    if (i == 6) return {model[6][7:3], strapIn};
    if (i == 7) return {revId, vendorId};
    return 8'h00;
  endfunction

  function automatic void applyWrite(input int i, input logic [7:0] d);
    if (i < 6) model[i] = d;
    else if (i == 6) model[6] = {d[7:3], 3'b000};
    else if (i == 8) model[8] = d;
  endfunction

  task automatic busStart();
    hostLow = 1'b0; hold(H);
    sclDrv = 1'b1;  hold(H);
    hostLow = 1'b1; hold(H);
    sclDrv = 1'b0;  hold(H);
  endtask

  task automatic busStop();
    hostLow = 1'b1; hold(H);
    sclDrv = 1'b1;  hold(H);
    hostLow = 1'b0; hold(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hostLow = !b[i]; hold(H);
      sclDrv = 1'b1;   hold(H);
      sclDrv = 1'b0;   hold(2);
    end
    hostLow = 1'b0; hold(H);
    sclDrv = 1'b1;  hold(H/2);
    acked = !sdaIn; hold(H/2);
    sclDrv = 1'b0;  hold(2);
  endtask

  task automatic recvByte(output logic [7:0] b, input bit giveAck);
    hostLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      sclDrv = 1'b1; hold(H/2);
      b[i] = sdaIn;  hold(H/2);
      sclDrv = 1'b0; hold(2);
    end
    hostLow = giveAck; hold(H);
    sclDrv = 1'b1;     hold(H);
    sclDrv = 1'b0;     hold(2);
    hostLow = 1'b0;
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 8; i++)
      chk(ctrlOut[i*8 +: 8] == expRead(i), req, $sformatf("ctrl byte %0d", i),
          ctrlOut[i*8 +: 8], expRead(i));
  endtask

  task automatic doWrite(input int n, input int x, input int nBytes,
                         input bit withStop, input string req);
    bit a;
    bit allAck = 1'b1;
    busStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'(n), a); allAck &= a;
    sendByte(8'(x), a); allAck &= a;
    for (int k = 0; k < nBytes; k++) begin
      sendByte(txBuf[k], a); allAck &= a;
      if (k < x) applyWrite(n + k, txBuf[k]);
    end
    if (withStop) busStop();
    chk(allAck, req, $sformatf("all bytes acked, index %0d", n), allAck, 1);
  endtask

  task automatic doRead(input int n, input int nData);
    bit a;
    bit allAck = 1'b1;
    logic [7:0] got;
    busStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'(n), a); allAck &= a;
    busStart();
    sendByte(8'hD3, a); allAck &= a;
    chk(allAck, "R5", $sformatf("read setup acked, index %0d", n), allAck, 1);
    recvByte(got, 1'b1);
    chk(got == model[8], "R7", "count byte", got, model[8]);
    for (int k = 0; k < nData; k++) begin
      recvByte(got, k != nData - 1);
      chk(got == expRead(n + k), "R5",
          $sformatf("read index %0d", n + k), got, expRead(n + k));
    end
    busStop();
    chk(sdaPullDown == 1'b0, "R5", "released after NACK", sdaPullDown, 0);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 9; i++) model[i] = 8'h00;
    model[0] = 8'hFF; model[1] = 8'hFF; model[2] = 8'hFF;
    model[4] = 8'h07; model[6] = 8'h08; model[8] = 8'd8;

    hold(5);
    rstN = 1'b1;
    hold(5);

    // R4 reset state
    checkRegs("R4");
    chk(ctrlOut[8] == 1'b1, "R4", "spread bit", ctrlOut[8], 1);
    chk(sdaPullDown == 1'b0, "R4", "idle pull-down", sdaPullDown, 0);
    doRead(0, 8);

    // R2 R6 R7 sweep of every starting index to the end of the map
    for (int n = 0; n <= 8; n++) begin
      for (int k = 0; k < 9 - n; k++) txBuf[k] = 8'(n * 53 + k * 29 + 17);
      doWrite(n, 9 - n, 9 - n, 1'b1, "R2");
      checkRegs("R6");
    end

    // R5 R7 read sweep including unmapped indexes
    for (int n = 0; n <= 10; n++) doRead(n, 5);

    // R3 surplus data bytes discarded
    for (int k = 0; k < 3; k++) txBuf[k] = 8'(8'hA0 + k);
    doWrite(2, 1, 3, 1'b1, "R3");
    checkRegs("R3");

    // R7 count register rewrite, index above 8 discarded
    txBuf[0] = 8'd4;
    doWrite(8, 1, 1, 1'b1, "R7");
    txBuf[0] = 8'h5A;
    doWrite(9, 1, 1, 1'b1, "R7");
    doRead(3, 4);

    // R1 unmatched address
    busStart();
    sendByte(8'hA4, a);
    chk(!a, "R1", "foreign address nacked", a, 0);
    sendByte(8'h00, a);
    chk(!a, "R1", "byte after foreign address nacked", a, 0);
    sendByte(8'h33, a);
    chk(!a, "R1", "later byte nacked", a, 0);
    busStop();
    checkRegs("R1");

    // R9 STOP in the middle of a write
    txBuf[0] = 8'h11; txBuf[1] = 8'h22;
    doWrite(0, 4, 1, 1'b1, "R9");
    checkRegs("R9");
    doRead(0, 3);

    // R6 strap change is reflected, writes to it ignored
    strapIn = 3'b101;
    hold(4);
    txBuf[0] = 8'h02; txBuf[1] = 8'hEE;
    doWrite(6, 2, 2, 1'b1, "R6");
    checkRegs("R6");
    doRead(6, 2);

    // R8 summary of the pull-down monitor
    chk(pdViolations == 0, "R8", "pull-down moves while SCL high",
        pdViolations, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule